// File: doc/BRIEF.md
# Dual-Mode Serial DAC Input Interface

This block is the digital front end of a serially loaded DAC. One serial data pin feeds a 16-bit DAC holding register in one of two modes. In three-wire mode, data is shifted in MSB first, one bit per clock, while the latch line is low. A rising edge on the latch line copies the shift register into the holding register in parallel. The serial output repeats the bits leaving the shift register, so several devices can share one chain.

Holding the latch line high switches the port to asynchronous mode. The clock then runs at 16 times the bit rate, and the data pin carries start/stop framed bytes. Two good frames, high byte first, form one word. A stop bit sampled low is a framing error. It is reported as a one-bit-long high pulse on the serial output, and the partial word is dropped.

A clear input forces the minimum code without touching the shift register. A registered range-select output tells the analog side which of four ranges is active.

Top module: `dsi_top`

## Requirements
- R1: While rst_ni is low, code_o is 0, sdo_o is 0, range_o is 0 and current_mode_o is 0.
- R2: On each rising clock edge with latch_i low, the 16-bit shift register takes sdi_i into bit 0 and moves every other bit one place toward bit 15. A word therefore enters MSB first.
- R3: A rising clock edge that sees latch_i high after it was low on the previous edge loads the shift register into code_o. While latch_i is high, the shift register does not change.
- R4: In three-wire mode, sdo_o equals bit 15 of the shift register and is updated on the falling clock edge. A word shifted in appears on sdo_o, MSB first, while the next 16 bits are shifted in.
- R5: On every edge that sees clear_i high, code_o becomes 0, and neither a latch load nor an asynchronous word may change it. After clear_i falls, code_o stays 0 until the next load. The shift register is not changed by clear_i.
- R6: The port is in asynchronous mode once latch_i has been high on 32 consecutive rising edges, and leaves it on the first edge that sees latch_i low. In asynchronous mode, sdo_o is low except for the framing-error pulse.
- R7: In asynchronous mode, a high-to-low transition on sdi_i starts a frame if sdi_i is still low on the 8th sample counted from that transition. Eight data bits follow, LSB first, each sampled 16 clocks after the previous sample point, and then a stop bit. After the second good frame, code_o becomes {first byte, second byte} on the edge that samples the stop bit.
- R8: A stop bit sampled low makes sdo_o high for exactly 16 clocks, starting at the edge that samples that stop bit. The frame is discarded, code_o is unchanged, and the next frame is taken as a high byte.
- R9: In asynchronous mode, a low on sdi_i that lasts fewer than 8 samples starts no frame and has no effect on code_o or on how the next frame is received.
- R10: range_o is range_sel_i registered for one clock. current_mode_o is 0 for code 2'b00, the voltage range, and 1 for codes 2'b01, 2'b10 and 2'b11, the three current ranges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock in three-wire mode, 16x bit clock in asynchronous mode |
| rst_ni | input | 1 | Active-low asynchronous reset |
| latch_i | input | 1 | Load strobe; held high selects asynchronous mode |
| sdi_i | input | 1 | Serial data input |
| clear_i | input | 1 | Forces the minimum DAC code |
| range_sel_i | input | 2 | Output range select |
| code_o | output | 16 | DAC holding register |
| sdo_o | output | 1 | Daisy-chain data or framing-error pulse |
| range_o | output | 2 | Registered range select |
| current_mode_o | output | 1 | High for a current range |

## Verification
The assertions assume that latch_i, sdi_i, clear_i and range_sel_i change only away from the rising edge, as synchronous inputs. They also assume that a latch pulse meant as a load stays well short of the 32-edge mode threshold. The stimulus drives every input 2 ns after a rising edge and keeps three-wire load pulses to a few cycles. In asynchronous mode it holds each bit for exactly 16 clocks, and it returns the line high for several bit times after a bad stop bit, so every start is a clean high-to-low transition.

// File: rtl/dsi_pkg.sv
package dsi_pkg;
  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;

  localparam logic [1:0] RANGE_VOLT = 2'b00;
endpackage

// File: rtl/dsi_mode_detect.sv
module dsi_mode_detect #(
  parameter int HOLD = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic latch_i,
  output logic async_o,
  output logic latch_rise_o
);
  localparam int HW = $clog2(HOLD + 1);
  localparam logic [HW-1:0] HOLD_V = HW'(HOLD);

  logic [HW-1:0] hold_cnt;
  logic          latch_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_cnt <= '0;
      latch_q  <= 1'b0;
    end else begin
      latch_q <= latch_i;
      if (!latch_i)              hold_cnt <= '0;
      else if (hold_cnt != HOLD_V) hold_cnt <= hold_cnt + 1'b1;
    end
  end

  assign async_o      = (hold_cnt == HOLD_V);
  assign latch_rise_o = latch_i & ~latch_q;

  // R6
  async_enter_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(async_o) |-> $past(latch_i));
  // R6
  async_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !latch_i |=> !async_o);
endmodule

// File: rtl/dsi_shift.sv
module dsi_shift #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_en_i,
  input  logic         sdi_i,
  output logic [W-1:0] word_o,
  output logic         sdo_o
);
  logic [W-1:0] sreg;
  logic         sdo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         sreg <= '0;
    else if (shift_en_i) sreg <= {sreg[W-2:0], sdi_i};
  end

  // daisy-chain output launched on the falling edge
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sdo_q <= 1'b0;
    else         sdo_q <= sreg[W-1];
  end

  assign word_o = sreg;
  assign sdo_o  = sdo_q;

  // R2
  shift_in_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_en_i |=> word_o[0] == $past(sdi_i));
  // R3
  shift_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_en_i |=> $stable(word_o));
endmodule

// File: rtl/dsi_async_rx.sv
module dsi_async_rx
  import dsi_pkg::*;
#(
  parameter int W       = 16,
  parameter int FRAME_W = 8,
  parameter int OS      = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         sdi_i,
  output logic [W-1:0] word_o,
  output logic         commit_o,
  output logic         err_o
);
  localparam int NF = W / FRAME_W;
  localparam int CW = $clog2(OS);
  localparam int BW = (FRAME_W > 1) ? $clog2(FRAME_W) : 1;
  localparam int FW = (NF > 1) ? $clog2(NF) : 1;
  localparam int EW = $clog2(OS + 1);
  localparam logic [CW-1:0] MID_V  = CW'(OS / 2 - 1);
  localparam logic [CW-1:0] LAST_V = CW'(OS - 1);
  localparam logic [BW-1:0] BLAST  = BW'(FRAME_W - 1);
  localparam logic [FW-1:0] FLAST  = FW'(NF - 1);
  localparam logic [EW-1:0] OS_V   = EW'(OS);

  rx_state_e          state;
  logic [CW-1:0]      cnt;
  logic [BW-1:0]      bitn;
  logic [FW-1:0]      fidx;
  logic [FRAME_W-1:0] rx_byte;
  logic [W-1:0]       asm_q;
  logic [EW-1:0]      err_cnt;
  logic               sdi_q;
  logic [W+FRAME_W-1:0] joined;
  logic               stop_pt;

  assign joined   = {asm_q, rx_byte};
  assign stop_pt  = (state == RX_STOP) && (cnt == LAST_V);
  assign word_o   = joined[W-1:0];
  assign commit_o = en_i && stop_pt && sdi_i && (fidx == FLAST);
  assign err_o    = (err_cnt != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sdi_q <= 1'b1;
    else         sdi_q <= sdi_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state   <= RX_IDLE;
      cnt     <= '0;
      bitn    <= '0;
      fidx    <= '0;
      rx_byte <= '0;
      asm_q   <= '0;
      err_cnt <= '0;
    end else if (!en_i) begin
      state   <= RX_IDLE;
      cnt     <= '0;
      bitn    <= '0;
      fidx    <= '0;
      err_cnt <= '0;
    end else begin
      if (err_cnt != '0) err_cnt <= err_cnt - 1'b1;
      unique case (state)
        RX_IDLE: begin
          if (sdi_q && !sdi_i) begin
            state <= RX_START;
            cnt   <= CW'(1);
          end
        end
        RX_START: begin
          if (cnt == MID_V) begin
            cnt  <= '0;
            bitn <= '0;
            state <= sdi_i ? RX_IDLE : RX_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_DATA: begin
          if (cnt == LAST_V) begin
            cnt     <= '0;
            rx_byte <= {sdi_i, rx_byte[FRAME_W-1:1]};
            if (bitn == BLAST) state <= RX_STOP;
            else               bitn  <= bitn + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_STOP: begin
          if (cnt == LAST_V) begin
            cnt   <= '0;
            state <= RX_IDLE;
            if (sdi_i) begin
              asm_q <= joined[W-1:0];
              fidx  <= (fidx == FLAST) ? '0 : fidx + 1'b1;
            end else begin
              err_cnt <= OS_V;
              fidx    <= '0;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  // R8
  err_after_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> $past(state == RX_STOP));
  // R7
  commit_no_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> !$rose(err_o));
endmodule

// File: rtl/dsi_top.sv
module dsi_top
  import dsi_pkg::*;
#(
  parameter int W       = 16,
  parameter int FRAME_W = 8,
  parameter int OS      = 16,
  parameter int HOLD    = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         latch_i,
  input  logic         sdi_i,
  input  logic         clear_i,
  input  logic [1:0]   range_sel_i,
  output logic [W-1:0] code_o,
  output logic         sdo_o,
  output logic [1:0]   range_o,
  output logic         current_mode_o
);
  logic         async_mode;
  logic         latch_rise;
  logic [W-1:0] sh_word;
  logic         sh_sdo;
  logic [W-1:0] rx_word;
  logic         rx_commit;
  logic         rx_err;
  logic [W-1:0] code_q;
  logic [1:0]   range_q;

  dsi_mode_detect #(.HOLD(HOLD)) u_mode (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .latch_i     (latch_i),
    .async_o     (async_mode),
    .latch_rise_o(latch_rise)
  );

  dsi_shift #(.W(W)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .shift_en_i(~latch_i),
    .sdi_i     (sdi_i),
    .word_o    (sh_word),
    .sdo_o     (sh_sdo)
  );

  dsi_async_rx #(.W(W), .FRAME_W(FRAME_W), .OS(OS)) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (async_mode),
    .sdi_i   (sdi_i),
    .word_o  (rx_word),
    .commit_o(rx_commit),
    .err_o   (rx_err)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q  <= '0;
      range_q <= RANGE_VOLT;
    end else begin
      range_q <= range_sel_i;
      if (clear_i)         code_q <= '0;
      else if (latch_rise) code_q <= sh_word;
      else if (rx_commit)  code_q <= rx_word;
    end
  end

  assign code_o         = code_q;
  assign range_o        = range_q;
  assign current_mode_o = (range_q != RANGE_VOLT);
  assign sdo_o          = async_mode ? rx_err : sh_sdo;

  // R5
  clear_force_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> code_o == '0);
  // R5
  code_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(code_o) |-> $past(clear_i || latch_rise || rx_commit));
  // R3
  load_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch_rise && !clear_i) |=> code_o == $past(sh_word));
endmodule

// File: tb/tb_dsi_top.sv
`timescale 1ns/1ps
module tb_dsi_top;
  localparam int HOLD = 32;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        latch_i = 1'b0;
  logic        sdi_i = 1'b0;
  logic        clear_i = 1'b0;
  logic [1:0]  range_sel_i = 2'b00;
  logic [15:0] code_o;
  logic        sdo_o;
  logic [1:0]  range_o;
  logic        current_mode_o;

  always #4 clk = ~clk;

  dsi_top dut (
    .clk_i(clk), .rst_ni(rst_ni), .latch_i(latch_i), .sdi_i(sdi_i),
    .clear_i(clear_i), .range_sel_i(range_sel_i), .code_o(code_o),
    .sdo_o(sdo_o), .range_o(range_o), .current_mode_o(current_mode_o)
  );

  typedef struct {
    int          kind;
    logic [15:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  // reference state derived from the requirements
  logic [15:0] m_shreg = '0, m_code = '0;
  logic [1:0]  m_range = '0, r_drive = '0;
  int          m_hold = 0, err_left = 0;
  bit          m_async = 0, in_reset = 1;
  logic        p_latch = 0, p_latch_q = 0, p_sdi = 0, p_clear = 0;
  logic [1:0]  p_range = '0;
  string       cur_tag = "R1";

  task automatic push(input int kind, input logic [15:0] exp, input string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    sb.push_back(it);
  endtask

  // monitor: compares queued expectations against the outputs
  initial begin
    forever begin
      @(posedge clk);
      #6;
      while (sb.size() > 0) begin
        item_t it;
        logic [15:0] act;
        it = sb.pop_front();
        case (it.kind)
          0: act = code_o;
          1: act = {15'b0, sdo_o};
          2: act = {14'b0, range_o};
          default: act = {15'b0, current_mode_o};
        endcase
        n_vec++;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s kind=%0d actual=%h expected=%h t=%0t", it.tag, it.kind, act, it.exp, $time);
        end
      end
    end
  end

  task automatic step(input logic l, input logic d, input logic c);
    @(posedge clk);
    if (!in_reset) begin
      if (p_clear) m_code = '0;
      else if (p_latch && !p_latch_q) m_code = m_shreg;
      if (!p_latch) m_shreg = {m_shreg[14:0], p_sdi};
      m_hold  = p_latch ? ((m_hold < HOLD) ? m_hold + 1 : HOLD) : 0;
      m_async = (m_hold == HOLD);
      m_range = p_range;
      p_latch_q = p_latch;
    end
    #2;
    latch_i = l; sdi_i = d; clear_i = c; range_sel_i = r_drive;
    p_latch = l; p_sdi = d; p_clear = c; p_range = r_drive;
    push(0, m_code, cur_tag);
    if (m_async) push(1, {15'b0, err_left > 0}, "R8");
    else         push(1, {15'b0, m_shreg[15]}, "R4");
    push(2, {14'b0, m_range}, "R10");
    push(3, {15'b0, m_range != 2'b00}, "R10");
    if (err_left > 0) err_left--;
  endtask

  task automatic tw_word(input logic [15:0] w);
    for (int i = 15; i >= 0; i--) step(1'b0, w[i], 1'b0);
    step(1'b1, 1'b0, 1'b0);
  endtask

  task automatic frame(input logic [7:0] b, input bit stop_ok, input bit last,
                       input logic [15:0] word);
    for (int c = 0; c < 160; c++) begin
      logic bv;
      if (c < 16)       bv = 1'b0;
      else if (c < 144) bv = b[(c - 16) / 16];
      else              bv = stop_ok;
      if (c == 152) begin
        if (!stop_ok)  err_left = 16;
        else if (last) m_code = word;
      end
      step(1'b1, bv, 1'b0);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b1, 1'b1, 1'b0);
  endtask

  initial begin
    // R1 reset state
    cur_tag = "R1";
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b0);
    @(posedge clk);
    #2 rst_ni = 1'b1;
    in_reset = 0;

    // R2 R3 R4 three-wire words and daisy chain
    cur_tag = "R3";
    tw_word(16'hA5C3);
    tw_word(16'h0F0F);
    step(1'b1, 1'b1, 1'b0);
    step(1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b1, 1'b0);
    cur_tag = "R2";
    tw_word(16'h8001);

    // R5 clear forces zero, shift register untouched
    cur_tag = "R5";
    step(1'b1, 1'b0, 1'b1);
    step(1'b1, 1'b0, 1'b1);
    step(1'b1, 1'b1, 1'b0);
    step(1'b1, 1'b1, 1'b0);
    step(1'b0, 1'b1, 1'b0);
    step(1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b1);
    step(1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b0);

    // R10 range select
    cur_tag = "R10";
    for (int r = 0; r < 4; r++) begin
      r_drive = 2'(r);
      step(1'b0, 1'b1, 1'b0);
      step(1'b0, 1'b0, 1'b0);
    end
    r_drive = 2'b00;
    step(1'b1, 1'b0, 1'b0);

    // R6 enter asynchronous mode
    cur_tag = "R6";
    step(1'b0, 1'b1, 1'b0);
    idle(40);

    // R7 two good frames
    cur_tag = "R7";
    frame(8'h3C, 1, 0, 16'h0);
    frame(8'h96, 1, 1, 16'h3C96);
    idle(20);

    // R8 bad stop on second frame, then on first frame
    cur_tag = "R8";
    frame(8'h12, 1, 0, 16'h0);
    frame(8'h34, 0, 0, 16'h0);
    idle(40);
    frame(8'h55, 0, 0, 16'h0);
    idle(40);
    frame(8'hBE, 1, 0, 16'h0);
    frame(8'hEF, 1, 1, 16'hBEEF);
    idle(20);

    // R9 short low pulse is not a start
    cur_tag = "R9";
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0);
    idle(20);
    frame(8'h81, 1, 0, 16'h0);
    frame(8'h7E, 1, 1, 16'h817E);
    idle(20);

    // R6 back to three-wire
    cur_tag = "R6";
    tw_word(16'h1234);
    step(1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b0);

    @(posedge clk);
    #8;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule